// File: doc/BRIEF.md
# General-Purpose I/O Port with PWM Pin Takeover

This block is an 8-pin general-purpose I/O port. Software reaches it through a small register bus that has write strobe, address and write data inputs and a combinational read data output. Through that bus it programs an output latch, a per-pin direction, a per-pin interrupt enable, a per-pin edge polarity and a set of sticky interrupt flags. Pin inputs are resynchronised by a flop chain. That synchronised state feeds the read-back path and the edge detectors.

Six of the pins can be taken over by PWM channels. While a channel is enabled, its level drives the pin and the output enable is forced on. Pin 5 is also taken over when an external emergency shut-down enable is asserted. The output latch keeps accepting writes during a takeover, so the pin returns to the latched value when the takeover ends. One pin position (bit 6) is absent: it reads 0 in every register and never drives.

The bus carries only single-cycle register accesses, and the pads are plain level signals. None of the interfaces has data that can stall, so no valid/ready handshake is used and no back-pressure applies.

Top module: `gpio_pwm_port`

## Requirements
- R1: After reset, every register (latch, direction, interrupt enable, flags, edge polarity) reads 0, `pad_oe` is 0 and `irq` is 0.
- R2: Bit 6 is unimplemented. It reads 0 from every register, writes to it are ignored, and `pad_oe[6]` and `pad_out[6]` stay 0.
- R3: A read of address 0 returns, for each bit, the latch bit when that bit's direction is 1, and the synchronised pin when that bit's direction is 0. A pin change becomes visible two clock edges after it is applied.
- R4: On a pin that is not taken over, `pad_out` follows the latch bit and `pad_oe` follows the direction bit (1 = output).
- R5: On pins 0 to 4, while `pwm_en[i]` is 1, `pad_out[i]` equals `pwm_level[i]` and `pad_oe[i]` is 1, whatever the direction bit is. Pin 7 has no takeover.
- R6: Pin 5 is taken over by `pwm_level[5]`, with `pad_oe[5]` forced to 1, when `pwm_en[5]` or `esd_en` is 1.
- R7: Latch writes made during a takeover are stored. When the takeover is released, the pin drives the stored value.
- R8: A flag bit sets on a rising edge (polarity bit = 1) or a falling edge (polarity bit = 0) of its synchronised pin, only if its enable bit is 1. This holds whether the pin is an input or an output. `irq` is the OR of all flags that are set and enabled.
- R9: Writing 1 to a bit at address 3 clears that flag, and writing 0 leaves it unchanged. A flag that is not written stays set.
- R10: Register map: address 0 = latch, 1 = direction, 2 = interrupt enable, 3 = flags, 4 = edge polarity. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| pad_in | input | 8 | Pin input levels (asynchronous) |
| pad_out | output | 8 | Pin output values |
| pad_oe | output | 8 | Pin output enables |
| pwm_en | input | 6 | Per-channel PWM enables for pins 0 to 5 |
| pwm_level | input | 6 | PWM channel output levels |
| esd_en | input | 1 | Emergency shut-down enable, takes over pin 5 |
| irq | output | 1 | Combined pin interrupt |

## Verification
The bench builds the port with its default parameters: eight pins, six PWM channels, the shut-down takeover on pin 5, the hole at bit 6 and a two-stage synchroniser. These values put the absent bit, the second takeover source on pin 5 and the pin 7 that has no alternate function all within reach of the stimulus. The two-stage synchroniser fixes the edge-to-flag latency that the checks rely on. Interrupt edges are driven on pins set as outputs, and on a disabled pin and the hole.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_LATCH = 3'd0,
    REG_DIR   = 3'd1,
    REG_IEN   = 3'd2,
    REG_FLAG  = 3'd3,
    REG_EDGE  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_override.sv
module gpio_port_override #(
  parameter int WIDTH   = 8,
  parameter int NUM_ALT = 6,
  parameter int ESD_PIN = 5
) (
  input  logic [WIDTH-1:0]   latch,
  input  logic [WIDTH-1:0]   dir,
  input  logic [NUM_ALT-1:0] alt_en,
  input  logic [NUM_ALT-1:0] alt_level,
  input  logic               esd_en,
  output logic [WIDTH-1:0]   pad_out,
  output logic [WIDTH-1:0]   pad_oe
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i < NUM_ALT) begin : g_alt
      logic take;
      if (i == ESD_PIN) begin : g_esd
        assign take = alt_en[i] | esd_en;
      end else begin : g_plain_alt
        assign take = alt_en[i];
      end
      assign pad_out[i] = take ? alt_level[i] : latch[i];
      assign pad_oe[i]  = take | dir[i];
    end else begin : g_gpio
      assign pad_out[i] = latch[i];
      assign pad_oe[i]  = dir[i];
    end
  end
endmodule

// File: rtl/gpio_port_edge_irq.sv
module gpio_port_edge_irq #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic [WIDTH-1:0] enable,
  input  logic [WIDTH-1:0] rise_sel,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] flags,
  output logic             irq
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] rise, fall, hit;

  always_comb begin
    rise = pin_sync & ~prev_q;
    fall = ~pin_sync & prev_q;
    hit  = ((rise & rise_sel) | (fall & ~rise_sel)) & enable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flags  <= '0;
    end else begin
      prev_q <= pin_sync;
      // a new edge wins over a clear in the same cycle
      flags  <= (flags & ~clr_mask) | hit;
    end
  end

  assign irq = |(flags & enable);
endmodule

// File: rtl/gpio_pwm_port.sv
module gpio_pwm_port
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH       = 8,
  parameter int               NUM_PWM     = 6,
  parameter int               ESD_PIN     = 5,
  parameter int               SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] IMPL_MASK   = 8'hBF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WIDTH-1:0]  reg_wdata,
  output logic [WIDTH-1:0]  reg_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  input  logic [NUM_PWM-1:0] pwm_en,
  input  logic [NUM_PWM-1:0] pwm_level,
  input  logic              esd_en,
  output logic              irq
);
  logic [WIDTH-1:0] latch_q, dir_q, ien_q, edge_q;
  logic [WIDTH-1:0] pin_sync, flag_q, clr_mask, wmask;
  reg_sel_e         sel;

  assign sel   = reg_sel_e'(reg_addr);
  assign wmask = reg_wdata & IMPL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      ien_q   <= '0;
      edge_q  <= '0;
    end else if (reg_we) begin
      case (sel)
        REG_LATCH: latch_q <= wmask;
        REG_DIR:   dir_q   <= wmask;
        REG_IEN:   ien_q   <= wmask;
        REG_EDGE:  edge_q  <= wmask;
        default: ;
      endcase
    end
  end

  assign clr_mask = (reg_we && sel == REG_FLAG) ? wmask : '0;

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  gpio_port_override #(.WIDTH(WIDTH), .NUM_ALT(NUM_PWM), .ESD_PIN(ESD_PIN)) u_ovr (
    .latch(latch_q), .dir(dir_q), .alt_en(pwm_en), .alt_level(pwm_level),
    .esd_en(esd_en), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  gpio_port_edge_irq #(.WIDTH(WIDTH)) u_irq (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .enable(ien_q),
    .rise_sel(edge_q), .clr_mask(clr_mask), .flags(flag_q), .irq(irq)
  );

  always_comb begin
    case (sel)
      REG_LATCH: reg_rdata = (latch_q & dir_q) | (pin_sync & ~dir_q);
      REG_DIR:   reg_rdata = dir_q;
      REG_IEN:   reg_rdata = ien_q;
      REG_FLAG:  reg_rdata = flag_q;
      REG_EDGE:  reg_rdata = edge_q;
      default:   reg_rdata = '0;
    endcase
    reg_rdata = reg_rdata & IMPL_MASK;
  end
endmodule

// File: rtl/gpio_pwm_port_chk.sv
module gpio_pwm_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [2:0] reg_addr,
  input logic [5:0] pwm_en,
  input logic [5:0] pwm_level,
  input logic       esd_en,
  input logic [7:0] pad_out,
  input logic [7:0] pad_oe,
  input logic [7:0] latch_q,
  input logic [7:0] dir_q,
  input logic [7:0] flag_q
);
  assert_pwm_takeover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_en[4:0] & ~pad_oe[4:0]) == 5'd0) &&
    ((pwm_en[4:0] & (pad_out[4:0] ^ pwm_level[4:0])) == 5'd0));

  assert_esd_takeover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    esd_en |-> (pad_oe[5] && pad_out[5] == pwm_level[5]));

  assert_hole_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe[6] && !pad_out[6] && !latch_q[6] && !dir_q[6] && !flag_q[6]);

  assert_pin7_gpio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[7] == dir_q[7] && pad_out[7] == latch_q[7]);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 3'd3) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

bind gpio_pwm_port gpio_pwm_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .pwm_en(pwm_en), .pwm_level(pwm_level), .esd_en(esd_en),
  .pad_out(pad_out), .pad_oe(pad_oe), .latch_q(latch_q), .dir_q(dir_q),
  .flag_q(flag_q)
);

// File: tb/tb_gpio_pwm_port.sv
module tb_gpio_pwm_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe;
  logic [5:0] pwm_en = '0;
  logic [5:0] pwm_level = '0;
  logic       esd_en = 1'b0;
  logic       irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // scoreboard queues: 0 = reg_rdata, 1 = pad_out, 2 = pad_oe, 3 = irq
  int         q_kind[$];
  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #5 clk = ~clk;

  gpio_pwm_port dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pwm_en(pwm_en),
    .pwm_level(pwm_level), .esd_en(esd_en), .irq(irq)
  );

  // monitor: compares queued expectations shortly after each falling edge
  always @(negedge clk) begin
    #1;
    while (q_kind.size() > 0) begin
      int k;
      logic [7:0] e, act;
      string t;
      k = q_kind.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      case (k)
        0: act = reg_rdata;
        1: act = pad_out;
        2: act = pad_oe;
        default: act = {7'd0, irq};
      endcase
      compared++;
      if (act !== e) begin
        mismatched++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, act, e);
      end
    end
  end

  task automatic push(input int kind, input logic [7:0] exp, input string tag);
    q_kind.push_back(kind);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    reg_addr = a;
    push(0, e, tag);
    @(negedge clk);
  endtask

  task automatic exp_pin(input int kind, input logic [7:0] e, input string tag);
    push(kind, e, tag);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) exp_rd(3'(a), 8'h00, "R1");
    exp_pin(2, 8'h00, "R1");
    exp_pin(3, 8'h00, "R1");

    // R3 input read-back through the synchroniser; R2 hole reads 0
    pad_in = 8'hE5;
    @(negedge clk);
    exp_rd(3'd0, 8'h00, "R3");      // one edge seen only
    exp_rd(3'd0, 8'hA5, "R3");      // second edge: visible, bit 6 masked (R2)

    // R4 mixed direction, R3 per-bit source
    wr(3'd0, 8'h3C);
    wr(3'd1, 8'hF0);
    exp_rd(3'd0, 8'h35, "R3");
    exp_pin(1, 8'h3C, "R4");
    exp_pin(2, 8'hB0, "R4");

    // R2 writes to bit 6 ignored; R10 direction read-back
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'hFF);
    exp_rd(3'd1, 8'hBF, "R2");
    exp_rd(3'd0, 8'hBF, "R2");
    exp_pin(2, 8'hBF, "R2");
    exp_pin(1, 8'hBF, "R2");

    // R5 PWM takeover on pins 0..4
    wr(3'd0, 8'h00);
    pwm_en = 6'h05; pwm_level = 6'h01;
    @(negedge clk);
    exp_pin(1, 8'h01, "R5");
    wr(3'd1, 8'h00);
    exp_pin(2, 8'h05, "R5");

    // R6 pin 5 by shut-down, then by its own channel
    pwm_en = 6'h00; pwm_level = 6'h20; esd_en = 1'b1;
    @(negedge clk);
    exp_pin(2, 8'h20, "R6");
    exp_pin(1, 8'h20, "R6");
    esd_en = 1'b0; pwm_en = 6'h20;
    @(negedge clk);
    exp_pin(2, 8'h20, "R6");
    pwm_en = 6'h00;
    @(negedge clk);
    exp_pin(2, 8'h00, "R6");

    // R7 latch updated under takeover, restored on release
    wr(3'd1, 8'hFF);
    pwm_en = 6'h01; pwm_level = 6'h00;
    wr(3'd0, 8'h01);
    exp_pin(1, 8'h00, "R7");
    pwm_en = 6'h00;
    @(negedge clk);
    exp_pin(1, 8'h01, "R7");

    // R8 edges on output-mode pins; pin 7 rising, pin 0 falling, pin 1 disabled
    pad_in = 8'h00;
    idle(4);
    wr(3'd2, 8'hFD);
    wr(3'd4, 8'h80);
    exp_rd(3'd4, 8'h80, "R10");
    pad_in = 8'hC3;
    idle(4);
    exp_rd(3'd3, 8'h80, "R8");
    exp_pin(3, 8'h01, "R8");

    // R9 write-1-to-clear, zero bits untouched
    wr(3'd3, 8'h00);
    exp_rd(3'd3, 8'h80, "R9");
    wr(3'd3, 8'h80);
    exp_rd(3'd3, 8'h00, "R9");
    exp_pin(3, 8'h00, "R9");

    // R8 falling edge on pin 0; rising pin 0 earlier did not count
    pad_in = 8'h82;
    idle(4);
    exp_rd(3'd3, 8'h01, "R8");
    exp_pin(3, 8'h01, "R8");
    // R8 disabling the pin masks irq but keeps the flag
    wr(3'd2, 8'h00);
    exp_pin(3, 8'h00, "R8");
    exp_rd(3'd3, 8'h01, "R8");

    // R10 unmapped addresses
    exp_rd(3'd5, 8'h00, "R10");
    exp_rd(3'd7, 8'h00, "R10");

    idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule